// File: doc/BRIEF.md
# Bus-Invert Coding Link

This block sends parallel words across a heavily loaded bus while keeping the number of wires that switch on each transfer low. Next to the data lines it adds one polarity line. When a new word arrives with its valid strobe, the encoder compares it with what the bus is currently driving. It then puts either the word itself or its bitwise complement on the bus, whichever flips fewer wires. The flip of the polarity line itself counts in that choice.

The receiving side undoes the coding with no delay. It XORs the bus data with the polarity bit copied across every bit position, so the decoded output always matches the word that was last accepted. When no valid word is presented, the bus keeps its value, so idle cycles cause no switching at all. The only parameter is the data width. Both even and odd widths are supported.

Top module: `bic_link`

## Requirements
- R1: In the cycle after synchronous reset is high, the bus data lines, the polarity line and the decoded output are all 0.
- R2: While in_valid is low, bus_data and bus_inv keep their values at every clock edge.
- R3: One clock edge after a word is accepted, out_data equals that word. The bus then carries the word unchanged with bus_inv=0, or its bitwise complement with bus_inv=1.
- R4: On an accepted word, let h be the number of bits where the word differs from the current bus_data. The cost of sending it true is h plus 1 if bus_inv is currently 1. The cost of sending it inverted is DATA_W-h plus 1 if bus_inv is currently 0. The encoder sets bus_inv=1 exactly when the inverted cost is strictly lower.
- R5: When the two costs are equal (possible only for odd DATA_W), the encoder sets bus_inv to 0.
- R6: For each accepted word, the number of toggles across the data lines plus the polarity line is at most DATA_W/2+1, and never more than (DATA_W+1)/2 rounded down.
- R7: out_data is a pure function of the bus lines, so it changes in the same cycle as the bus and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on in_data is to be transferred |
| in_data | input | DATA_W | Source word |
| bus_data | output | DATA_W | Encoded data lines |
| bus_inv | output | 1 | Polarity line, 1 means data lines carry the complement |
| out_data | output | DATA_W | Decoded word at the receiver |

## Verification
The bus lines and the decoded word change at the clock edge that accepts a word, so every result is due one edge after its stimulus. The bench drives inputs on the falling edge. It advances a behavioural model by one transfer and compares all outputs at the next falling edge, so each comparison lands half a period after the edge that produced it. Two instances, one with an even width and one with an odd width, are checked side by side. This covers the case where the two costs can tie.

// File: rtl/bic_pkg.sv
package bic_pkg;

    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_INV  = 1'b1
    } pol_e;

    function automatic int unsigned cnt_w(input int unsigned w);
        return $clog2(w + 1) + 1;
    endfunction

endpackage

// File: rtl/bic_popcount.sv
module bic_popcount #(
    parameter int unsigned W = 8,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < int'(W); i++) begin
            ones = ones + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/bic_encoder.sv
module bic_encoder
    import bic_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] bus_data,
    output pol_e              bus_pol
);
    localparam int unsigned HW = $clog2(DATA_W + 1);
    localparam int unsigned KW = cnt_w(DATA_W);
    localparam logic [KW-1:0] FULL = KW'(DATA_W);

    typedef struct packed {
        pol_e              pol;
        logic [DATA_W-1:0] data;
    } bus_t;

    bus_t         cur_q, nxt;
    logic [HW-1:0] diff_ones;
    logic [KW-1:0] cost_true, cost_inv;

    bic_popcount #(.W(DATA_W)) u_pop (
        .vec  (in_data ^ cur_q.data),
        .ones (diff_ones)
    );

    always_comb begin
        cost_true = KW'(diff_ones) + KW'(cur_q.pol == POL_INV);
        cost_inv  = FULL - KW'(diff_ones) + KW'(cur_q.pol == POL_TRUE);
        if (cost_inv < cost_true) begin
            nxt.pol  = POL_INV;
            nxt.data = ~in_data;
        end else begin
            nxt.pol  = POL_TRUE;
            nxt.data = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{pol: POL_TRUE, data: '0};
        end else if (in_valid) begin
            cur_q <= nxt;
        end
    end

    assign bus_data = cur_q.data;
    assign bus_pol  = cur_q.pol;
endmodule

// File: rtl/bic_decoder.sv
module bic_decoder
    import bic_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] bus_data,
    input  pol_e              bus_pol,
    output logic [DATA_W-1:0] word
);
    assign word = bus_data ^ {DATA_W{bus_pol == POL_INV}};
endmodule

// File: rtl/bic_link.sv
module bic_link
    import bic_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_inv,
    output logic [DATA_W-1:0] out_data
);
    pol_e pol;

    bic_encoder #(.DATA_W(DATA_W)) u_enc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .bus_data (bus_data),
        .bus_pol  (pol)
    );

    bic_decoder #(.DATA_W(DATA_W)) u_dec (
        .bus_data (bus_data),
        .bus_pol  (pol),
        .word     (out_data)
    );

    assign bus_inv = (pol == POL_INV);
endmodule

// File: rtl/bic_link_chk.sv
module bic_link_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_inv,
    input logic [DATA_W-1:0] out_data
);
    localparam int LIMIT = int'(DATA_W) / 2 + 1;
    localparam int FULL  = int'(DATA_W) + 1;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (bus_data == '0 && !bus_inv && out_data == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(bus_data) && $stable(bus_inv)));

    p_decode_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_data == $past(in_data)));

    p_better_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (2 * ($countones(bus_data ^ $past(bus_data))
                         + int'(bus_inv != $past(bus_inv))) <= FULL));

    p_tie_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (2 * $countones(in_data ^ bus_data) + 2 * int'(bus_inv) == FULL))
        |=> !bus_inv);

    p_bound_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (($countones(bus_data ^ $past(bus_data))
                       + int'(bus_inv != $past(bus_inv))) <= LIMIT));

    p_comb_r7: assert property (@(posedge clk) disable iff (rst)
        $stable(bus_data) && $stable(bus_inv) |-> $stable(out_data));
endmodule

bind bic_link bic_link_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .bus_data (bus_data),
    .bus_inv  (bus_inv),
    .out_data (out_data)
);

// File: tb/tb_bic_link.sv
module tb_bic_link;
    localparam int CLK_PERIOD = 10;
    localparam int WE = 8;
    localparam int WO = 7;

    logic clk = 1'b0;
    logic rst;
    logic vld;
    logic [WE-1:0] din;
    logic [WE-1:0] bus_e, out_e;
    logic [WO-1:0] bus_o, out_o;
    logic inv_e, inv_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int ref_bus [2];
    int ref_inv [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bic_link #(.DATA_W(WE)) dut (
        .clk(clk), .rst(rst), .in_valid(vld), .in_data(din),
        .bus_data(bus_e), .bus_inv(inv_e), .out_data(out_e)
    );

    bic_link #(.DATA_W(WO)) dut_odd (
        .clk(clk), .rst(rst), .in_valid(vld), .in_data(din[WO-1:0]),
        .bus_data(bus_o), .bus_inv(inv_o), .out_data(out_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 32; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // One transfer through the model; returns 1 on a cost tie.
    function automatic bit model_step(input int k, input int w, input int d);
        int mask = (1 << w) - 1;
        int h = ones((d ^ ref_bus[k]) & mask);
        int ct = h + ref_inv[k];
        int ci = w - h + 1 - ref_inv[k];
        if (ci < ct) begin
            ref_bus[k] = ~d & mask;
            ref_inv[k] = 1;
        end else begin
            ref_bus[k] = d & mask;
            ref_inv[k] = 0;
        end
        return ct == ci;
    endfunction

    task automatic compare(input int k, input int w, input int prev_bus, input int prev_inv,
                           input bit was_valid, input bit tie, input int word);
        int b   = (k == 0) ? int'(bus_e) : int'(bus_o);
        int iv  = (k == 0) ? int'(inv_e) : int'(inv_o);
        int o   = (k == 0) ? int'(out_e) : int'(out_o);
        int mask = (1 << w) - 1;
        int tog = ones(b ^ prev_bus) + ((iv != prev_inv) ? 1 : 0);
        if (!was_valid) begin
            check(b == prev_bus && iv == prev_inv, "R2 hold", (iv << 16) | b, (prev_inv << 16) | prev_bus);
        end else begin
            check(iv == ref_inv[k], tie ? "R5 tie polarity" : "R4 polarity", iv, ref_inv[k]);
            check(b == ref_bus[k], "R4 bus data", b, ref_bus[k]);
            check(o == (word & mask), "R3 decoded word", o, word & mask);
            check(tog <= w / 2 + 1 && 2 * tog <= w + 1, "R6 toggle bound", tog, w / 2 + 1);
        end
        check(o == ((b ^ (iv != 0 ? mask : 0)) & mask), "R7 decode from lines", o, (b ^ (iv != 0 ? mask : 0)) & mask);
    endtask

    // Drive at falling edge, compare at next falling edge.
    task automatic xfer(input bit v, input int d);
        int pb [2];
        int pi [2];
        bit tie [2];
        int wd [2];
        wd[0] = WE;
        wd[1] = WO;
        for (int k = 0; k < 2; k++) begin
            pb[k] = ref_bus[k];
            pi[k] = ref_inv[k];
            tie[k] = 1'b0;
        end
        vld = v;
        din = WE'(d);
        if (v) for (int k = 0; k < 2; k++) tie[k] = model_step(k, wd[k], d);
        @(negedge clk);
        for (int k = 0; k < 2; k++) compare(k, wd[k], pb[k], pi[k], v, tie[k], d);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 2; k++) begin
            ref_bus[k] = 0;
            ref_inv[k] = 0;
        end
        check(bus_e == '0 && !inv_e && out_e == '0, "R1 reset even", {inv_e, bus_e}, 0);
        check(bus_o == '0 && !inv_o && out_o == '0, "R1 reset odd", {inv_o, bus_o}, 0);
    endtask

    initial begin
        int lfsr = 16'hACE1;
        rst = 1'b1;
        vld = 1'b0;
        din = '0;
        @(negedge clk);
        do_reset();
        // R4: all ones from zero flips only the polarity line
        xfer(1'b1, 8'hFF);
        check(bus_e == 8'h00 && inv_e, "R4 all-ones inverted", {inv_e, bus_e}, 9'h100);
        // R2: idle cycles with changing data
        xfer(1'b0, 8'h5A);
        xfer(1'b0, 8'h00);
        // R3: back to true form
        xfer(1'b1, 8'h00);
        xfer(1'b1, 8'h01);
        // R5: odd width tie, from zero bus with INV 0 and four differing bits
        do_reset();
        xfer(1'b1, 8'h0F);
        check(inv_o == 1'b0 && bus_o == 7'h0F, "R5 tie keeps true", {inv_o, bus_o}, 8'h0F);
        // R4: even width, five bits differing from zero gives 5 versus 4
        do_reset();
        xfer(1'b1, 8'h1F);
        check(inv_e && bus_e == 8'hE0, "R4 majority inverted", {inv_e, bus_e}, 9'h1E0);
        // alternating patterns
        xfer(1'b1, 8'hAA);
        xfer(1'b1, 8'h55);
        xfer(1'b1, 8'hAA);
        // pseudo-random traffic with idle gaps
        for (int n = 0; n < 400; n++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
            xfer((lfsr & 3) != 0, lfsr >> 4);
        end
        // reset mid-stream
        do_reset();
        xfer(1'b1, 8'hF0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule